// File: doc/BRIEF.md
# Mode-banked processor register file

This block holds the integer register state of a 32-bit load/store processor core. Software sees sixteen registers, selected by a 4-bit index, together with a current status word. Which physical storage those registers occupy depends on the operating mode, which is carried in the low five bits of the current status word. Every privileged exception mode has its own stack pointer (index 13) and link register (index 14). The fast-interrupt mode also has private copies of indices 8 to 12. The program counter (index 15) is a single register that all modes share. Each exception mode also owns a saved status word. User and System modes have no saved status word.

The datapath reads two operands and writes one result per cycle. Reads are combinational. Writes take effect at the clock edge. Privileged code can raise a user-bank select so that its port accesses reach the User-mode copies, which is how a context switch saves and restores a task. A separate link strobe loads a return address into the current mode's link register in the same cycle as a program counter update. A flag port updates only the four condition bits at the top of the status word. The block does not sequence exception entry. It only stores and steers state, and the surrounding control logic changes mode by writing the status word.

Top module: `bankreg_file`

## Requirements
- R1: After reset the mode field (status bits [4:0]) reads 10011 (Supervisor), all other status bits are zero, and every general register, saved status word and the program counter read zero.
- R2: Mode codes are User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undef 11011 and System 11111. Any other code asserts `illegal_mode`, uses the User bank, is treated as unprivileged and has no saved status word.
- R3: Indices 0 to 7 and index 15 name the same storage in every mode.
- R4: In FIQ mode (10001), indices 8 to 12 reach private storage. Every other mode shares the User copies of indices 8 to 12.
- R5: FIQ, IRQ, Supervisor, Abort and Undef each have private copies of indices 13 and 14. System mode uses the User copies.
- R6: Each of the five exception modes has its own saved status word. In User, System or an illegal mode, `sst_invalid` is 1, `sst_rdata` reads zero and `sst_we` has no effect.
- R7: A port write to index 15 and a `pc_we` load both store the value with bits [1:0] cleared. When both happen in the same cycle, `pc_wdata` wins.
- R8: When `user_sel` is 1 in a privileged mode, port reads and port writes of indices 8 to 14 reach the User copies. In User or illegal modes, `user_sel` has no effect.
- R9: Status bits [31:28] hold N, Z, C, V from the top down. A `flag_we` write changes only those bits and overrides a same-cycle full status write on those bits.
- R10: `link_we` writes `link_addr` into the current mode's index 14 regardless of `user_sel`. If a port write reaches the same physical register in that cycle, the link value is kept.
- R11: Read ports show register contents combinationally. A write becomes visible on the read ports in the cycle after its clock edge.
- R12: `stat_we` replaces the whole status word, including the mode field. The new mode governs bank selection from the next cycle on, and same-cycle accesses still use the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_idx | input | 4 | Read port A register index |
| ra_data | output | 32 | Read port A data |
| rb_idx | input | 4 | Read port B register index |
| rb_data | output | 32 | Read port B data |
| w_en | input | 1 | Result write enable |
| w_idx | input | 4 | Result write index |
| w_data | input | 32 | Result write data |
| user_sel | input | 1 | Steer port accesses to User copies (privileged modes) |
| pc_we | input | 1 | Program counter load |
| pc_wdata | input | 32 | Program counter load value |
| pc_q | output | 32 | Current program counter |
| link_we | input | 1 | Return-address strobe into current mode's index 14 |
| link_addr | input | 32 | Return address |
| stat_we | input | 1 | Full status word write |
| stat_wdata | input | 32 | Status word write value |
| flag_we | input | 1 | Condition flag write |
| flag_wdata | input | 4 | N, Z, C, V (bit 3 = N) |
| status_q | output | 32 | Current status word, mode in bits [4:0] |
| sst_we | input | 1 | Saved status write for the current mode |
| sst_wdata | input | 32 | Saved status write value |
| sst_rdata | output | 32 | Saved status of the current mode |
| sst_invalid | output | 1 | Current mode has no saved status word |
| illegal_mode | output | 1 | Mode field holds an unlisted code |

## Verification
The assertions check on every cycle the properties that hold in any state: the program counter stays word aligned, the illegal-mode and missing-saved-status flags agree with the mode code, the saved status reads zero when it is absent, flag and program-counter loads land one cycle later, and a link strobe is visible in index 14 on the following cycle. Bank aliasing can only be shown by the bench's scenarios. These are FIQ-private indices 8 to 12, the per-mode copies of indices 13 and 14, System sharing User storage, user-bank steering and the priority between colliding writes. The bench writes values in one mode and reads them back after mode changes against a behavioural model of the seven mode views.

// File: rtl/bankreg_pkg.sv
`timescale 1ns/1ps
package bankreg_pkg;

   localparam int MODE_W     = 5;
   localparam int IDX_W      = 4;
   localparam int NUM_BANKS  = 6;                 // user, fiq, irq, svc, abt, und
   localparam int SHARED_CNT = 8;                 // indices 0..7 common to all
   localparam int FIQ_PRIV   = 5;                 // indices 8..12 private to fiq
   localparam int PAIR_CNT   = 2;                 // indices 13,14 per bank
   localparam int FIQ_BASE   = SHARED_CNT + FIQ_PRIV;          // first fiq copy
   localparam int PAIR_BASE  = FIQ_BASE + FIQ_PRIV;            // first pair copy
   localparam int NUM_GPR    = PAIR_BASE + PAIR_CNT * NUM_BANKS;
   localparam int PHYS_W     = $clog2(NUM_GPR);
   localparam int BANK_W     = $clog2(NUM_BANKS);

   typedef enum logic [MODE_W-1:0] {
      MODE_USR = 5'b10000,
      MODE_FIQ = 5'b10001,
      MODE_IRQ = 5'b10010,
      MODE_SVC = 5'b10011,
      MODE_ABT = 5'b10111,
      MODE_UND = 5'b11011,
      MODE_SYS = 5'b11111
   } mode_e;

   typedef enum logic [BANK_W-1:0] {
      BANK_USR = 3'd0,
      BANK_FIQ = 3'd1,
      BANK_IRQ = 3'd2,
      BANK_SVC = 3'd3,
      BANK_ABT = 3'd4,
      BANK_UND = 3'd5
   } bank_e;

   localparam logic [IDX_W-1:0] IDX_LR = 4'd14;
   localparam logic [IDX_W-1:0] IDX_PC = 4'd15;

   // Architectural index + bank -> physical slot of the general store.
   function automatic logic [PHYS_W-1:0] phys_of(input logic [IDX_W-1:0] idx,
                                                  input bank_e bank);
      int p;
      int i;
      i = int'(idx);
      if (i < SHARED_CNT)
         p = i;
      else if (i < SHARED_CNT + FIQ_PRIV)
         p = (bank == BANK_FIQ) ? (i + FIQ_PRIV) : i;
      else if (i < SHARED_CNT + FIQ_PRIV + PAIR_CNT)
         p = PAIR_BASE + PAIR_CNT * int'(bank) + (i - FIQ_BASE);
      else
         p = 0;                                   // program counter, not stored here
      return PHYS_W'(p);
   endfunction

endpackage

// File: rtl/bankreg_mode_decode.sv
`timescale 1ns/1ps
module bankreg_mode_decode
   import bankreg_pkg::*;
(
   input  logic [MODE_W-1:0] mode_i,
   output bank_e             bank_o,
   output logic              priv_o,
   output logic              sst_ok_o,
   output logic              illegal_o
);

   always_comb begin
      bank_o    = BANK_USR;
      priv_o    = 1'b1;
      sst_ok_o  = 1'b1;
      illegal_o = 1'b0;
      case (mode_i)
         MODE_USR: begin priv_o = 1'b0; sst_ok_o = 1'b0; end
         MODE_FIQ: bank_o = BANK_FIQ;
         MODE_IRQ: bank_o = BANK_IRQ;
         MODE_SVC: bank_o = BANK_SVC;
         MODE_ABT: bank_o = BANK_ABT;
         MODE_UND: bank_o = BANK_UND;
         MODE_SYS: sst_ok_o = 1'b0;
         default: begin
            priv_o    = 1'b0;
            sst_ok_o  = 1'b0;
            illegal_o = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/bankreg_index_map.sv
`timescale 1ns/1ps
module bankreg_index_map
   import bankreg_pkg::*;
(
   input  logic [IDX_W-1:0]  idx_i,
   input  bank_e             bank_i,
   output logic [PHYS_W-1:0] phys_o
);

   assign phys_o = phys_of(idx_i, bank_i);

endmodule

// File: rtl/bankreg_gpr_store.sv
`timescale 1ns/1ps
module bankreg_gpr_store #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 30,
   parameter int PHYS_W   = 5,
   parameter int NUM_RD   = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            pw_en,     // result port (low priority)
   input  logic [PHYS_W-1:0]               pw_phys,
   input  logic [DATA_W-1:0]               pw_data,
   input  logic                            lw_en,     // link strobe (high priority)
   input  logic [PHYS_W-1:0]               lw_phys,
   input  logic [DATA_W-1:0]               lw_data,
   input  logic [NUM_RD-1:0][PHYS_W-1:0]   rd_phys,
   output logic [NUM_RD-1:0][DATA_W-1:0]   rd_data
);

   logic [DATA_W-1:0] regs [NUM_REGS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic hit_p;
      logic hit_l;
      assign hit_p = pw_en && (pw_phys == PHYS_W'(g));
      assign hit_l = lw_en && (lw_phys == PHYS_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[g] <= '0;
         else if (hit_l)
            regs[g] <= lw_data;
         else if (hit_p)
            regs[g] <= pw_data;
      end
   end

   for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
      assign rd_data[r] = (int'(rd_phys[r]) < NUM_REGS) ? regs[rd_phys[r]] : '0;
   end

endmodule

// File: rtl/bankreg_status.sv
`timescale 1ns/1ps
module bankreg_status #(
   parameter int                DATA_W   = 32,
   parameter int                MODE_W   = 5,
   parameter int                FLAG_W   = 4,
   parameter int                NUM_SST  = 5,
   parameter int                SEL_W    = 3,
   parameter logic [MODE_W-1:0] RST_MODE = 5'b10011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_we,
   input  logic [DATA_W-1:0] stat_wdata,
   input  logic              flag_we,
   input  logic [FLAG_W-1:0] flag_wdata,
   input  logic              sst_we,
   input  logic              sst_valid,
   input  logic [SEL_W-1:0]  sst_sel,     // bank number, 1..NUM_SST
   input  logic [DATA_W-1:0] sst_wdata,
   output logic [DATA_W-1:0] status_q,
   output logic [DATA_W-1:0] sst_rdata
);

   localparam logic [DATA_W-1:0] RST_STATUS = {{(DATA_W-MODE_W){1'b0}}, RST_MODE};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= RST_STATUS;
      end else begin
         if (stat_we)
            status_q <= stat_wdata;
         if (flag_we)
            status_q[DATA_W-1 -: FLAG_W] <= flag_wdata;
      end
   end

   logic [DATA_W-1:0] sst [NUM_SST];

   for (genvar g = 0; g < NUM_SST; g++) begin : g_sst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sst[g] <= '0;
         else if (sst_we && sst_valid && (sst_sel == SEL_W'(g + 1)))
            sst[g] <= sst_wdata;
      end
   end

   logic [DATA_W-1:0] sst_pick;
   always_comb begin
      sst_pick = '0;
      for (int k = 0; k < NUM_SST; k++)
         if (sst_sel == SEL_W'(k + 1))
            sst_pick = sst[k];
   end

   assign sst_rdata = sst_valid ? sst_pick : '0;

endmodule

// File: rtl/bankreg_file.sv
`timescale 1ns/1ps
module bankreg_file
   import bankreg_pkg::*;
#(
   parameter int              DATA_W      = 32,
   parameter int              INSTR_BYTES = 4,
   parameter int              FLAG_W      = 4,
   parameter logic [31:0]     RST_PC      = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        ra_idx,
   output logic [DATA_W-1:0] ra_data,
   input  logic [3:0]        rb_idx,
   output logic [DATA_W-1:0] rb_data,
   input  logic              w_en,
   input  logic [3:0]        w_idx,
   input  logic [DATA_W-1:0] w_data,
   input  logic              user_sel,
   input  logic              pc_we,
   input  logic [DATA_W-1:0] pc_wdata,
   output logic [DATA_W-1:0] pc_q,
   input  logic              link_we,
   input  logic [DATA_W-1:0] link_addr,
   input  logic              stat_we,
   input  logic [DATA_W-1:0] stat_wdata,
   input  logic              flag_we,
   input  logic [FLAG_W-1:0] flag_wdata,
   output logic [DATA_W-1:0] status_q,
   input  logic              sst_we,
   input  logic [DATA_W-1:0] sst_wdata,
   output logic [DATA_W-1:0] sst_rdata,
   output logic              sst_invalid,
   output logic              illegal_mode
);

   localparam int ALIGN_BITS = $clog2(INSTR_BYTES);
   localparam int NUM_SST    = NUM_BANKS - 1;
   localparam int NUM_RD     = 2;

   // elaboration-time parameter checks
   if (DATA_W < MODE_W + FLAG_W) begin : g_bad_width
      $error("bankreg_file: DATA_W too small for mode and flag fields");
   end
   if ((1 << ALIGN_BITS) != INSTR_BYTES) begin : g_bad_align
      $error("bankreg_file: INSTR_BYTES must be a power of two");
   end
   if (DATA_W > 32) begin : g_bad_pc
      $error("bankreg_file: DATA_W above 32 not supported by RST_PC");
   end

   // ---------------- mode decode ----------------
   bank_e cur_bank;
   bank_e acc_bank;
   logic  cur_priv;
   logic  cur_sst_ok;

   bankreg_mode_decode u_dec (
      .mode_i    (status_q[MODE_W-1:0]),
      .bank_o    (cur_bank),
      .priv_o    (cur_priv),
      .sst_ok_o  (cur_sst_ok),
      .illegal_o (illegal_mode)
   );

   assign acc_bank = (user_sel && cur_priv) ? BANK_USR : cur_bank;

   // ---------------- index mapping ----------------
   logic [PHYS_W-1:0] phys_a, phys_b, phys_w, phys_l;

   bankreg_index_map u_map_a (.idx_i(ra_idx), .bank_i(acc_bank), .phys_o(phys_a));
   bankreg_index_map u_map_b (.idx_i(rb_idx), .bank_i(acc_bank), .phys_o(phys_b));
   bankreg_index_map u_map_w (.idx_i(w_idx),  .bank_i(acc_bank), .phys_o(phys_w));
   bankreg_index_map u_map_l (.idx_i(IDX_LR), .bank_i(cur_bank), .phys_o(phys_l));

   // ---------------- general registers ----------------
   logic [NUM_RD-1:0][PHYS_W-1:0] rd_phys;
   logic [NUM_RD-1:0][DATA_W-1:0] rd_data;

   assign rd_phys[0] = phys_a;
   assign rd_phys[1] = phys_b;

   bankreg_gpr_store #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_GPR),
      .PHYS_W   (PHYS_W),
      .NUM_RD   (NUM_RD)
   ) u_gpr (
      .clk     (clk),
      .rst_n   (rst_n),
      .pw_en   (w_en && (w_idx != IDX_PC)),
      .pw_phys (phys_w),
      .pw_data (w_data),
      .lw_en   (link_we),
      .lw_phys (phys_l),
      .lw_data (link_addr),
      .rd_phys (rd_phys),
      .rd_data (rd_data)
   );

   // ---------------- program counter ----------------
   logic              pc_load;
   logic [DATA_W-1:0] pc_src;
   logic [DATA_W-1:0] pc_aligned;

   assign pc_load = pc_we || (w_en && (w_idx == IDX_PC));
   assign pc_src  = pc_we ? pc_wdata : w_data;

   if (ALIGN_BITS > 0) begin : g_align
      assign pc_aligned = {pc_src[DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
   end else begin : g_noalign
      assign pc_aligned = pc_src;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc_q <= DATA_W'(RST_PC) & ~DATA_W'(INSTR_BYTES - 1);
      else if (pc_load)
         pc_q <= pc_aligned;
   end

   assign ra_data = (ra_idx == IDX_PC) ? pc_q : rd_data[0];
   assign rb_data = (rb_idx == IDX_PC) ? pc_q : rd_data[1];

   // ---------------- status words ----------------
   bankreg_status #(
      .DATA_W   (DATA_W),
      .MODE_W   (MODE_W),
      .FLAG_W   (FLAG_W),
      .NUM_SST  (NUM_SST),
      .SEL_W    (BANK_W),
      .RST_MODE (MODE_SVC)
   ) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .stat_we    (stat_we),
      .stat_wdata (stat_wdata),
      .flag_we    (flag_we),
      .flag_wdata (flag_wdata),
      .sst_we     (sst_we),
      .sst_valid  (cur_sst_ok),
      .sst_sel    (cur_bank),
      .sst_wdata  (sst_wdata),
      .status_q   (status_q),
      .sst_rdata  (sst_rdata)
   );

   assign sst_invalid = !cur_sst_ok;

endmodule

// File: rtl/bankreg_checker.sv
`timescale 1ns/1ps
module bankreg_checker
   import bankreg_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int INSTR_BYTES = 4,
   parameter int FLAG_W      = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        ra_idx,
   input logic [DATA_W-1:0] ra_data,
   input logic [3:0]        rb_idx,
   input logic [DATA_W-1:0] rb_data,
   input logic              w_en,
   input logic [3:0]        w_idx,
   input logic [DATA_W-1:0] w_data,
   input logic              user_sel,
   input logic              pc_we,
   input logic [DATA_W-1:0] pc_wdata,
   input logic [DATA_W-1:0] pc_q,
   input logic              link_we,
   input logic [DATA_W-1:0] link_addr,
   input logic              stat_we,
   input logic [DATA_W-1:0] stat_wdata,
   input logic              flag_we,
   input logic [FLAG_W-1:0] flag_wdata,
   input logic [DATA_W-1:0] status_q,
   input logic              sst_we,
   input logic [DATA_W-1:0] sst_wdata,
   input logic [DATA_W-1:0] sst_rdata,
   input logic              sst_invalid,
   input logic              illegal_mode
);

   localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'(INSTR_BYTES - 1);

   logic [4:0] md;
   logic       listed;
   assign md = status_q[4:0];
   assign listed = (md == 5'b10000) || (md == 5'b10001) || (md == 5'b10010) ||
                   (md == 5'b10011) || (md == 5'b10111) || (md == 5'b11011) ||
                   (md == 5'b11111);

   p_reset_svc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (md == 5'b10011));

   p_illegal_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_mode == !listed);

   p_no_sst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sst_invalid == (!listed || md == 5'b10000 || md == 5'b11111));

   p_sst_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sst_invalid |-> (sst_rdata == '0));

   p_pc_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_q & LOW_MASK) == '0);

   p_pc_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_idx == 4'd15) |-> (rb_data == pc_q));

   p_pc_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pc_we |=> (pc_q == ($past(pc_wdata) & ~LOW_MASK)));

   p_flag_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |=> (status_q[DATA_W-1 -: FLAG_W] == $past(flag_wdata)));

   p_link_seen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((ra_idx == 4'd14) && !user_sel && $past(link_we) && !$past(stat_we))
      |-> (ra_data == $past(link_addr)));

endmodule

bind bankreg_file bankreg_checker #(
   .DATA_W      (DATA_W),
   .INSTR_BYTES (INSTR_BYTES),
   .FLAG_W      (FLAG_W)
) u_chk (.*);

// File: tb/sim_bankreg_file.sv
`timescale 1ns/1ps
module sim_bankreg_file;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ra_idx = '0, rb_idx = '0, w_idx = '0;
   logic [31:0] ra_data, rb_data;
   logic        w_en = 1'b0;
   logic [31:0] w_data = '0;
   logic        user_sel = 1'b0;
   logic        pc_we = 1'b0;
   logic [31:0] pc_wdata = '0;
   logic [31:0] pc_q;
   logic        link_we = 1'b0;
   logic [31:0] link_addr = '0;
   logic        stat_we = 1'b0;
   logic [31:0] stat_wdata = '0;
   logic        flag_we = 1'b0;
   logic [3:0]  flag_wdata = '0;
   logic [31:0] status_q;
   logic        sst_we = 1'b0;
   logic [31:0] sst_wdata = '0;
   logic [31:0] sst_rdata;
   logic        sst_invalid;
   logic        illegal_mode;

   bankreg_file u0 (.*);

   always #10 clk = ~clk;   // 50 MHz

   int    vectors = 0;
   int    fails = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // ---- reference model: one view of 15 registers per mode slot ----
   // slot 0 user, 1 fiq, 2 irq, 3 svc, 4 abt, 5 und, 6 sys
   logic [31:0] mv  [7][15];
   logic [31:0] msp [7];
   logic [31:0] mpc;
   logic [31:0] mst;

   logic [4:0] mode_codes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                  5'b10111, 5'b11011, 5'b11111, 5'b01010};

   function automatic int slot_of(logic [4:0] m);
      case (m)
         5'b10000: return 0;
         5'b10001: return 1;
         5'b10010: return 2;
         5'b10011: return 3;
         5'b10111: return 4;
         5'b11011: return 5;
         5'b11111: return 6;
         default:  return -1;
      endcase
   endfunction

   function automatic int group_of(int s);
      return (s == 6) ? 0 : s;
   endfunction

   function automatic bit shares(int a, int b, int idx);
      if (idx < 8) return 1'b1;
      if (idx < 13) return (a == 1) == (b == 1);
      return group_of(a) == group_of(b);
   endfunction

   task automatic mwrite(int s, int idx, logic [31:0] v);
      for (int s2 = 0; s2 < 7; s2++)
         if (shares(s, s2, idx)) mv[s2][idx] = v;
   endtask

   task automatic mreset();
      for (int s = 0; s < 7; s++) begin
         msp[s] = '0;
         for (int i = 0; i < 15; i++) mv[s][i] = '0;
      end
      mpc = '0;
      mst = 32'h0000_0013;
   endtask

   task automatic view(output int s, output int acc, output bit inv, output bit ill);
      bit priv;
      s = slot_of(mst[4:0]);
      ill = (s < 0);
      if (ill) s = 0;
      priv = !ill && (s != 0);
      acc = (user_sel && priv) ? 0 : s;
      inv = ill || (s == 0) || (s == 6);
   endtask

   task automatic cmp(string name, logic [31:0] got, logic [31:0] exp);
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", cur_req, name, got, exp);
      end
   endtask

   task automatic check_now();
      int s, acc; bit inv, ill;
      logic [31:0] ea, eb;
      view(s, acc, inv, ill);
      ea = (ra_idx == 4'd15) ? mpc : mv[acc][int'(ra_idx)];
      eb = (rb_idx == 4'd15) ? mpc : mv[acc][int'(rb_idx)];
      vectors++;
      cmp("ra_data", ra_data, ea);
      cmp("rb_data", rb_data, eb);
      cmp("pc_q", pc_q, mpc);
      cmp("status_q", status_q, mst);
      cmp("sst_rdata", sst_rdata, inv ? 32'h0 : msp[s]);
      cmp("sst_invalid", {31'b0, sst_invalid}, {31'b0, inv});
      cmp("illegal_mode", {31'b0, illegal_mode}, {31'b0, ill});
   endtask

   task automatic mupdate();
      int s, acc; bit inv, ill;
      view(s, acc, inv, ill);
      if (w_en) begin
         if (w_idx == 4'd15) begin
            if (!pc_we) mpc = w_data & ~32'd3;
         end else
            mwrite(acc, int'(w_idx), w_data);
      end
      if (pc_we) mpc = pc_wdata & ~32'd3;
      if (link_we) mwrite(s, 14, link_addr);
      if (sst_we && !inv) msp[s] = sst_wdata;
      if (stat_we) mst = stat_wdata;
      if (flag_we) mst[31:28] = flag_wdata;
   endtask

   // one vector: settle, compare, advance model, wait to next falling edge
   task automatic tick();
      #2;
      check_now();
      mupdate();
      @(negedge clk);
   endtask

   task automatic idle();
      w_en = 0; pc_we = 0; link_we = 0; stat_we = 0; flag_we = 0; sst_we = 0;
      user_sel = 0;
   endtask

   task automatic set_mode(logic [4:0] m);
      stat_we = 1; stat_wdata = {mst[31:5], m};
      tick();
      stat_we = 0;
   endtask

   task automatic wr(logic [3:0] i, logic [31:0] v);
      w_en = 1; w_idx = i; w_data = v;
      tick();
      w_en = 0;
   endtask

   task automatic sweep();
      for (int i = 0; i < 8; i++) begin
         ra_idx = 4'(2 * i); rb_idx = 4'(2 * i + 1);
         tick();
      end
   endtask

   initial begin
      mreset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      cur_req = "R1";
      sweep();

      // R3, R5: fill all indices in Supervisor, read back
      cur_req = "R3";
      for (int i = 0; i < 15; i++) wr(4'(i), 32'h5000_0000 + 32'(i));
      sweep();

      // R4, R12: fiq private 8..12 and pair; mode change takes effect next cycle
      cur_req = "R12";
      stat_we = 1; stat_wdata = 32'h0000_0011; ra_idx = 4'd9; rb_idx = 4'd13;
      tick();
      stat_we = 0;
      cur_req = "R4";
      for (int i = 8; i < 15; i++) wr(4'(i), 32'hF100_0000 + 32'(i));
      sweep();
      set_mode(5'b10000);
      sweep();

      // R5: each exception mode gets its own 13/14; system uses user's
      cur_req = "R5";
      for (int m = 0; m < 7; m++) begin
         set_mode(mode_codes[m]);
         wr(4'd13, 32'hA000_0000 + 32'(m));
         wr(4'd14, 32'hB000_0000 + 32'(m));
      end
      for (int m = 0; m < 7; m++) begin
         set_mode(mode_codes[m]);
         ra_idx = 4'd13; rb_idx = 4'd14; tick();
         ra_idx = 4'd8;  rb_idx = 4'd3;  tick();
      end

      // R6: saved status per mode, ignored in user/system/illegal
      cur_req = "R6";
      for (int m = 0; m < 8; m++) begin
         set_mode(mode_codes[m]);
         sst_we = 1; sst_wdata = 32'h5500_0000 + 32'(m); tick();
         sst_we = 0; tick();
      end
      for (int m = 0; m < 8; m++) set_mode(mode_codes[m]);

      // R7: pc alignment and pc_we priority
      cur_req = "R7";
      set_mode(5'b10011);
      ra_idx = 4'd15; rb_idx = 4'd15;
      wr(4'd15, 32'h1234_5677);
      tick();
      w_en = 1; w_idx = 4'd15; w_data = 32'hDEAD_BEE1;
      pc_we = 1; pc_wdata = 32'h0000_8003;
      tick();
      idle(); tick();

      // R8: user-bank steering in privileged mode, and no effect in user mode
      cur_req = "R8";
      set_mode(5'b10010);
      user_sel = 1; ra_idx = 4'd13; rb_idx = 4'd10;
      wr(4'd13, 32'h0C0C_0013);
      wr(4'd10, 32'h0C0C_0010);
      user_sel = 0; tick();
      set_mode(5'b10001);
      user_sel = 1; wr(4'd11, 32'h0D0D_0011); ra_idx = 4'd11; tick();
      user_sel = 0; tick();
      set_mode(5'b10000);
      user_sel = 1; wr(4'd14, 32'h0E0E_0014); ra_idx = 4'd14; tick();
      user_sel = 0; tick();

      // R9: flags only touch top bits, override a full write there
      cur_req = "R9";
      set_mode(5'b10111);
      flag_we = 1; flag_wdata = 4'b1010; tick();
      flag_we = 0; tick();
      stat_we = 1; stat_wdata = 32'h3000_00D7; flag_we = 1; flag_wdata = 4'b0101;
      tick();
      idle(); tick();

      // R10: link wins over colliding port write; ignores user_sel
      cur_req = "R10";
      set_mode(5'b11011);
      ra_idx = 4'd14; rb_idx = 4'd15;
      w_en = 1; w_idx = 4'd14; w_data = 32'h1111_1111;
      link_we = 1; link_addr = 32'h2222_2222; pc_we = 1; pc_wdata = 32'h0000_4000;
      tick();
      idle(); tick();
      user_sel = 1; w_en = 1; w_idx = 4'd14; w_data = 32'h3333_3333;
      link_we = 1; link_addr = 32'h4444_4444;
      tick();
      idle(); tick();
      user_sel = 1; tick(); user_sel = 0;

      // R2: illegal mode falls back to user bank, unprivileged
      cur_req = "R2";
      set_mode(5'b00110);
      sweep();
      user_sel = 1; wr(4'd13, 32'h7777_0013); user_sel = 0;
      set_mode(5'b10000);
      ra_idx = 4'd13; tick();

      // R11: random traffic against the model, every cycle compared
      cur_req = "R11";
      for (int n = 0; n < 1500; n++) begin
         ra_idx = 4'($urandom); rb_idx = 4'($urandom);
         w_en = 1'($urandom); w_idx = 4'($urandom); w_data = $urandom;
         user_sel = 1'($urandom);
         pc_we = ($urandom % 8) == 0; pc_wdata = $urandom;
         link_we = ($urandom % 6) == 0; link_addr = $urandom;
         stat_we = ($urandom % 10) == 0;
         stat_wdata = {$urandom_range(0, 32'h07FF_FFFF) << 5} | 32'(mode_codes[$urandom % 8]);
         flag_we = ($urandom % 5) == 0; flag_wdata = 4'($urandom);
         sst_we = ($urandom % 4) == 0; sst_wdata = $urandom;
         tick();
      end
      idle(); tick();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL R11 watchdog: got hung run expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule